// File: doc/BRIEF.md
# Bypassable Signed Partial Product Generator

This block forms the partial product bit array of a 9x9 two's complement multiplier using the Baugh-Wooley arrangement. The array is 82 bits wide, and each bit carries a fixed column weight (rank). Sign handling is built into the array: the cross terms that pair a sign bit with a non-sign bit are inverted, one constant 1 is added, and the top bit of the reduced sum is flipped. As a result, the downstream reduction logic only has to add unsigned columns.

Every bit of the array passes through its own 2:1 selector. When the select is asserted, a caller-supplied 82-bit bus replaces the generated bits. The same reduction path then sums arbitrary addend bits at the same ranks, which makes it usable for multi-operand addition. A simple column reduction is included so that the product, or the bypassed sum, is visible at a port. The outputs are registered when the `OUT_REG` parameter is 1 (the default) and purely combinational when it is 0.

Top module: `bw_ppg`

## Requirements
- R1: While `rst_n` is low with `OUT_REG`=1, `pp_bits` and `result` are all zeros regardless of the inputs.
- R2: In multiply mode (`bypass`=0), for i and j both below 8, or both equal to 8, `pp_bits[9*j+i]` equals `op_a[i] & op_b[j]` and has rank i+j.
- R3: In multiply mode, when exactly one of i or j equals 8, `pp_bits[9*j+i]` equals the NAND of `op_a[i]` and `op_b[j]`.
- R4: In multiply mode, `pp_bits[81]` is the constant 1 and has rank 9.
- R5: In multiply mode, `result` equals the 18-bit two's complement product of `op_a` and `op_b` for every operand pair.
- R6: In bypass mode (`bypass`=1), `pp_bits` equals `byp_bits` bit for bit.
- R7: In bypass mode, changing `op_a` or `op_b` changes neither `pp_bits` nor `result`.
- R8: In bypass mode, `result` is the sum over k of `byp_bits[k]` shifted left by the rank of k, where the rank is (k mod 9)+(k div 9) for k<81 and 9 for k=81. The sum is taken modulo 2^18, and then bit 17 is inverted.
- R9: With `OUT_REG`=1, each output reflects the inputs sampled at the preceding rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| bypass | input | 1 | 1 selects `byp_bits` in place of the generated array |
| op_a | input | 9 | Signed multiplicand |
| op_b | input | 9 | Signed multiplier |
| byp_bits | input | 82 | Raw addend bits used in bypass mode |
| pp_bits | output | 82 | Selected partial product bits, index 9*j+i plus the constant at 81 |
| result | output | 18 | Column sum of `pp_bits` with bit 17 inverted |

## Verification
The hardest case to reach is one where the sign-correction terms alone decide the outcome. This happens when one operand is the most negative value (-256) and the other sweeps through every value, and when both operands are negative. The stimulus covers these with a full sweep of one operand against a fixed set of edge values, then adds a pseudo-random walk for general coverage. Independence from the operands in bypass mode is shown by holding a bypass pattern fixed while the operands change, and the rank weighting is checked by walking a single set bit across all 82 bypass positions.

// File: rtl/bw_ppg.sv
module bw_ppg #(
  parameter int W       = 9,
  parameter bit OUT_REG = 1'b1,
  localparam int NPP    = W*W + 1,
  localparam int PW     = 2*W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bypass,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [NPP-1:0] byp_bits,
  output logic [NPP-1:0] pp_bits,
  output logic [PW-1:0]  result
);
  logic [NPP-1:0] gen_bits;
  logic [NPP-1:0] sel_bits;
  logic [PW-1:0]  col_sum;

  function automatic int rank_of(int k);
    return (k == NPP-1) ? W : (k % W) + (k / W);
  endfunction

  for (genvar j = 0; j < W; j++) begin : g_row
    for (genvar i = 0; i < W; i++) begin : g_col
      if ((i == W-1) != (j == W-1)) begin : g_nand
        assign gen_bits[j*W+i] = ~(op_a[i] & op_b[j]);
      end else begin : g_and
        assign gen_bits[j*W+i] = op_a[i] & op_b[j];
      end
    end
  end
  assign gen_bits[NPP-1] = 1'b1;

  assign sel_bits = bypass ? byp_bits : gen_bits;

  always_comb begin
    col_sum = '0;
    for (int k = 0; k < NPP; k++)
      col_sum = col_sum + (PW'(sel_bits[k]) << rank_of(k));
    col_sum[PW-1] = ~col_sum[PW-1];
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pp_bits <= '0;
        result  <= '0;
      end else begin
        pp_bits <= sel_bits;
        result  <= col_sum;
      end
    end
  end else begin : g_comb
    assign pp_bits = sel_bits;
    assign result  = col_sum;
  end
endmodule

// File: rtl/bw_ppg_chk.sv
module bw_ppg_chk #(
  parameter int W       = 9,
  parameter bit OUT_REG = 1'b1,
  localparam int NPP    = W*W + 1,
  localparam int PW     = 2*W
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bypass,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [NPP-1:0] byp_bits,
  input logic [NPP-1:0] pp_bits,
  input logic [PW-1:0]  result
);
  logic           v;
  logic           bp_d;
  logic [W-1:0]   a_d, b_d;
  logic [NPP-1:0] byp_d;
  logic [PW-1:0]  prod_exp;

  if (OUT_REG) begin : g_lat
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v <= 1'b0; bp_d <= 1'b0; a_d <= '0; b_d <= '0; byp_d <= '0;
      end else begin
        v <= 1'b1; bp_d <= bypass; a_d <= op_a; b_d <= op_b; byp_d <= byp_bits;
      end
    end
  end else begin : g_now
    assign v     = 1'b1;
    assign bp_d  = bypass;
    assign a_d   = op_a;
    assign b_d   = op_b;
    assign byp_d = byp_bits;
  end

  assign prod_exp = PW'($signed(a_d) * $signed(b_d));

  a_r1_reset_clear: assert property (@(posedge clk)
    (OUT_REG && !rst_n) |=> (!rst_n |-> (pp_bits == '0 && result == '0)));

  a_r2_low_and: assert property (@(posedge clk) disable iff (!rst_n)
    (v && !bp_d) |-> (pp_bits[0] == (a_d[0] & b_d[0]) && pp_bits[NPP-2] == (a_d[W-1] & b_d[W-1])));

  a_r3_cross_nand: assert property (@(posedge clk) disable iff (!rst_n)
    (v && !bp_d) |-> (pp_bits[W-1] == ~(a_d[W-1] & b_d[0]) && pp_bits[(W-1)*W] == ~(a_d[0] & b_d[W-1])));

  a_r4_const_one: assert property (@(posedge clk) disable iff (!rst_n)
    (v && !bp_d) |-> pp_bits[NPP-1]);

  a_r5_product: assert property (@(posedge clk) disable iff (!rst_n)
    (v && !bp_d) |-> (result == prod_exp));

  a_r6_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (v && bp_d) |-> (pp_bits == byp_d));

  a_r7_operand_free: assert property (@(posedge clk) disable iff (!rst_n)
    (v && bp_d && $past(v && bp_d) && $stable(byp_d)) |-> ($stable(pp_bits) && $stable(result)));
endmodule

bind bw_ppg bw_ppg_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .op_a(op_a), .op_b(op_b),
  .byp_bits(byp_bits), .pp_bits(pp_bits), .result(result)
);

// File: tb/bw_ppg_bench.sv
module bw_ppg_bench;
  localparam int W = 9;
  localparam int NPP = W*W + 1;
  localparam int PW = 2*W;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bypass = 1'b0;
  logic [W-1:0]   op_a = '0, op_b = '0;
  logic [NPP-1:0] byp_bits = '0;
  logic [NPP-1:0] pp_bits;
  logic [PW-1:0]  result;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bw_ppg u_bw_ppg (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .op_a(op_a), .op_b(op_b),
    .byp_bits(byp_bits), .pp_bits(pp_bits), .result(result)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic bp, logic [W-1:0] a, logic [W-1:0] b, logic [NPP-1:0] byp);
    bypass = bp; op_a = a; op_b = b; byp_bits = byp;
    @(posedge clk); #2;
  endtask

  function automatic int rank_k(int k);
    return (k == NPP-1) ? W : (k % W) + (k / W);
  endfunction

  function automatic logic [NPP-1:0] exp_pp(logic [W-1:0] a, logic [W-1:0] b);
    logic [NPP-1:0] p;
    for (int j = 0; j < W; j++)
      for (int i = 0; i < W; i++) begin
        p[j*W+i] = a[i] & b[j];
        if ((i == W-1) != (j == W-1)) p[j*W+i] = ~p[j*W+i];
      end
    p[NPP-1] = 1'b1;
    return p;
  endfunction

  function automatic logic [PW-1:0] exp_byp_sum(logic [NPP-1:0] byp);
    logic [PW-1:0] s = '0;
    for (int k = 0; k < NPP; k++) if (byp[k]) s = s + (PW'(1) << rank_k(k));
    s[PW-1] = ~s[PW-1];
    return s;
  endfunction

  function automatic logic [PW-1:0] exp_prod(logic [W-1:0] a, logic [W-1:0] b);
    int pa = int'($signed(a));
    int pb = int'($signed(b));
    int pr = pa * pb;
    return PW'(pr);
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; bypass = 1'b1; op_a = 9'h1AB; op_b = 9'h0FF; byp_bits = '1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 pp", 128'(pp_bits), 128'(0));
    chk("R1 result", 128'(result), 128'(0));
    rst_n = 1'b1;
  endtask

  task automatic t_latency;
    apply(1'b0, 9'd3, 9'd5, '0);
    op_a = 9'd7; op_b = 9'd11; #1;
    chk("R9 holds prior product", 128'(result), 128'(exp_prod(9'd3, 9'd5)));
    @(posedge clk); #2;
    chk("R9 updates after edge", 128'(result), 128'(exp_prod(9'd7, 9'd11)));
  endtask

  task automatic t_bit_array;
    logic [W-1:0] av[4] = '{9'h100, 9'h0FF, 9'h1FF, 9'h155};
    logic [W-1:0] bv[4] = '{9'h100, 9'h0AA, 9'h001, 9'h1FF};
    for (int n = 0; n < 4; n++) begin
      apply(1'b0, av[n], bv[n], '1);
      for (int k = 0; k < NPP-1; k++) begin
        if (((k % W) == W-1) != ((k / W) == W-1))
          chk("R3 nand bit", 128'(pp_bits[k]), 128'(exp_pp(av[n], bv[n])[k]));
        else
          chk("R2 and bit", 128'(pp_bits[k]), 128'(exp_pp(av[n], bv[n])[k]));
      end
      chk("R4 const one", 128'(pp_bits[NPP-1]), 128'(1));
    end
  endtask

  task automatic t_product_sweep;
    logic [W-1:0] bv[8] = '{9'h100, 9'h1FF, 9'h000, 9'h001, 9'h0FF, 9'h101, 9'h080, 9'h17F};
    for (int n = 0; n < 8; n++)
      for (int a = 0; a < (1 << W); a++) begin
        apply(1'b0, W'(a), bv[n], '0);
        chk("R5 product sweep", 128'(result), 128'(exp_prod(W'(a), bv[n])));
      end
  endtask

  task automatic t_product_random;
    logic [17:0] lf = 18'h2B3C5;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[16:0], lf[17] ^ lf[10]};
      apply(1'b0, lf[8:0], lf[17:9], '0);
      chk("R5 product random", 128'(result), 128'(exp_prod(lf[8:0], lf[17:9])));
    end
  endtask

  task automatic t_bypass_walk;
    for (int k = 0; k < NPP; k++) begin
      logic [NPP-1:0] one = NPP'(1) << k;
      apply(1'b1, 9'h155, 9'h0AA, one);
      chk("R6 walk pp", 128'(pp_bits), 128'(one));
      chk("R8 walk sum", 128'(result), 128'(exp_byp_sum(one)));
    end
    apply(1'b1, 9'h000, 9'h000, '1);
    chk("R6 all ones pp", 128'(pp_bits), 128'({NPP{1'b1}}));
    chk("R8 all ones sum", 128'(result), 128'(exp_byp_sum('1)));
    apply(1'b1, 9'h1FF, 9'h1FF, '0);
    chk("R6 zeros pp", 128'(pp_bits), 128'(0));
    chk("R8 zeros sum", 128'(result), 128'(exp_byp_sum('0)));
  endtask

  task automatic t_bypass_independent;
    logic [NPP-1:0] pat = {2'b10, {40{2'b01}}};
    logic [W-1:0] av[5] = '{9'h000, 9'h1FF, 9'h100, 9'h0AB, 9'h07E};
    apply(1'b1, 9'h000, 9'h000, pat);
    for (int n = 0; n < 5; n++) begin
      apply(1'b1, av[n], ~av[n], pat);
      chk("R7 pp unchanged", 128'(pp_bits), 128'(pat));
      chk("R7 sum unchanged", 128'(result), 128'(exp_byp_sum(pat)));
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_bit_array();
    t_product_sweep();
    t_product_random();
    t_bypass_walk();
    t_bypass_independent();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule